// File: doc/BRIEF.md
# Slot-Timed Video Memory Write Queue

This block sits between a processor's data port and the video memories. Every data-port write is captured together with the current port address, the current access code and a ready time, and is placed in a four-entry ring queue. The queue is drained only when the display timing grants an external access slot. An entry may use a slot only once its ready time has been reached. A port write that arrives while the queue is full is held off through a ready/valid handshake until a slot frees an entry.

The block also produces the port status word with empty and full flags. It merges read data for the palette memory and the vertical scroll memory: the bits those memories do not store come from the stale queue entry that the next write will overwrite. A rebase input subtracts a common amount from the ready time of every pending entry, so the time base can be wrapped without disturbing the drain timing. The memory arrays themselves sit outside the block and receive a registered write strobe, a target select, an address and data.

Top module: `slot_write_queue`

## Requirements
- R1: After reset the queue is empty, the status word reads 0x3600, `wrReady` is high, and no memory write strobe and no unused-slot flag are raised.
- R2: The queue holds 4 entries. With 4 pending entries the status word reads 0x3500 and `wrReady` is low. A `wrValid` presented while full is neither stored nor counted for auto-increment. Status bit 9 means empty and bit 8 means full, on the fixed base 0x3400.
- R3: A pushed entry becomes ready at `nowTime` at the push plus slot length times 3, where the slot length is 16 when `wideMode` is 1 and 20 when it is 0. A slot drains the head only when its ready time is not greater than `nowTime`. A slot that finds the head not ready raises `slotUnused` one cycle later.
- R4: A slot granted while the queue is empty raises `slotUnused` in the next cycle and no write strobe.
- R5: A `rdReq` pulse makes the next granted slot serve the read. That slot raises `slotUnused`, drains nothing and clears the request, so the following slot drains normally.
- R6: A video RAM write (access code low nibble 0x1) drains over two slots. The first writes the high data byte to the entry address. The second writes the low byte to the address with bit 0 inverted and removes the entry. Bytes appear on `memData[7:0]` with target 0.
- R7: A palette write (code 0x3, target 1) and a scroll write (code 0x5, target 2) drain in one slot as a full 16-bit word at the entry address.
- R8: An entry whose code is not one of the three write codes is removed at its slot without a write strobe and without `slotUnused`.
- R9: `cfgLoad` sets the port address and access code. Each accepted push stores the current address and then adds `autoInc` to it.
- R10: Entries drain in push order across index wrap-around, and the queue reports empty after its last entry is removed.
- R11: With `rdSel`=0, `rdWord` is `rdRaw` masked with 0x0EEE, with all other bits taken from the value of the entry at the write index (the slot the next push uses; indices count accepted pushes modulo 4 from reset).
- R12: With `rdSel`=1, `rdWord` takes `rdRaw` bits 0x03FF and bits 0xF800 from the entry at the write index, leaving bit 10 zero. When `rdAddr[6:1]` is 40 or more, `rdWord` is 0.
- R13: A `rebaseValid` cycle subtracts `rebaseAmount` from the ready time of every pending entry and clamps the result at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nowTime | input | 32 | Free-running master-clock time |
| wideMode | input | 1 | 1 selects the 16-clock slot length, 0 the 20-clock length |
| cfgLoad | input | 1 | Loads port address and access code |
| cfgAddr | input | 16 | Port address to load |
| cfgCode | input | 6 | Access code to load |
| autoInc | input | 8 | Address increment applied per accepted push |
| wrValid | input | 1 | Data-port write request |
| wrData | input | 16 | Data-port write value |
| wrReady | output | 1 | Queue can accept a write |
| slotTick | input | 1 | External access slot granted this cycle |
| rdReq | input | 1 | Pending read claims the next slot |
| slotUnused | output | 1 | Previous slot did no queue drain |
| memWe | output | 1 | Memory write strobe |
| memTarget | output | 2 | 0 video RAM, 1 palette, 2 scroll memory |
| memAddr | output | 16 | Memory write address |
| memData | output | 16 | Memory write data (byte in bits 7:0 for video RAM) |
| statusWord | output | 16 | Status word with empty and full flags |
| rdSel | input | 1 | 0 palette read merge, 1 scroll read merge |
| rdAddr | input | 16 | Read address for the scroll range check |
| rdRaw | input | 16 | Word read from the memory |
| rdWord | output | 16 | Merged read word |
| rebaseValid | input | 1 | Apply a time rebase |
| rebaseAmount | input | 32 | Amount subtracted from pending ready times |

## Verification
A corrupted read or write index shows within one slot as a strobe with the wrong address or data, and as a status word whose empty or full flag disagrees with the number of writes accepted minus those drained. A wrong ready time shows at the first slot near the boundary as a `slotUnused` where a drain was due, or as an early drain. A lost partial flag on a video RAM entry repeats the high byte or skips it within two slots. A wrong write index shows at once in the merged read word, whose stale bits then come from the wrong earlier write.

// File: rtl/swq_pkg.sv
package swq_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 16;
  localparam int TIME_W = 32;
  localparam int CODE_W = 6;
  localparam int INC_W  = 8;

  localparam logic [3:0] CODE_VRAM_WR  = 4'h1;
  localparam logic [3:0] CODE_CRAM_WR  = 4'h3;
  localparam logic [3:0] CODE_VSRAM_WR = 4'h5;

  typedef enum logic [1:0] {
    TGT_VRAM  = 2'd0,
    TGT_CRAM  = 2'd1,
    TGT_VSRAM = 2'd2,
    TGT_NONE  = 2'd3
  } target_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic markPartial;
    logic emitHigh;
    logic emitWord;
    logic rebase;
  } ctrl_strobe_t;

  typedef struct packed {
    logic [TIME_W-1:0] readyTime;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] value;
    logic [CODE_W-1:0] code;
    logic              partial;
  } entry_t;

  function automatic target_e decodeTarget(input logic [3:0] c);
    case (c)
      CODE_VRAM_WR:  return TGT_VRAM;
      CODE_CRAM_WR:  return TGT_CRAM;
      CODE_VSRAM_WR: return TGT_VSRAM;
      default:       return TGT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/swq_control.sv
module swq_control
  import swq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             slotTick,
  input  logic             rdReq,
  input  logic             rebaseValid,
  input  logic             headReady,
  input  logic [3:0]       headCode,
  input  logic             headPartial,
  output ctrl_strobe_t     strobe,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx,
  output logic [DEPTH-1:0] validMask,
  output logic             wrReady,
  output logic             queueEmpty,
  output logic             queueFull,
  output logic             slotUnused
);
  // read pointer carries an extra top bit: set means "no valid head" (empty)
  logic [IDX_W:0]   rdPtr;
  logic [IDX_W:0]   rdPtrNext;
  logic [IDX_W-1:0] wrIdxNext;
  logic [IDX_W-1:0] rdAdv;
  logic [IDX_W-1:0] fillCount;
  logic             rdPending;
  logic             pendClear;
  logic             unusedNext;
  logic             headIsWrite;

  assign rdIdx      = rdPtr[IDX_W-1:0];
  assign queueEmpty = rdPtr[IDX_W];
  assign queueFull  = !queueEmpty && (rdIdx == wrIdx);
  assign wrReady    = !queueFull;
  assign fillCount  = wrIdx - rdIdx;
  assign headIsWrite = (decodeTarget(headCode) != TGT_NONE);

  always_comb begin
    strobe        = '0;
    strobe.push   = wrValid && !queueFull;
    strobe.rebase = rebaseValid;
    pendClear     = 1'b0;
    unusedNext    = 1'b0;
    if (slotTick) begin
      if (rdPending) begin
        pendClear  = 1'b1;
        unusedNext = 1'b1;
      end else if (!queueEmpty && headReady) begin
        if (headCode == CODE_VRAM_WR && !headPartial) begin
          strobe.emitHigh    = 1'b1;
          strobe.markPartial = 1'b1;
        end else begin
          strobe.pop      = 1'b1;
          strobe.emitWord = headIsWrite;
        end
      end else begin
        unusedNext = 1'b1;
      end
    end
  end

  always_comb begin
    wrIdxNext = strobe.push ? wrIdx + 1'b1 : wrIdx;
    rdAdv     = rdIdx + 1'b1;
    rdPtrNext = rdPtr;
    if (strobe.pop) begin
      if (rdAdv == wrIdx && !strobe.push) rdPtrNext = {1'b1, {IDX_W{1'b0}}};
      else                                rdPtrNext = {1'b0, rdAdv};
    end else if (strobe.push && queueEmpty) begin
      rdPtrNext = {1'b0, wrIdx};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr      <= {1'b1, {IDX_W{1'b0}}};
      wrIdx      <= '0;
      rdPending  <= 1'b0;
      slotUnused <= 1'b0;
    end else begin
      rdPtr      <= rdPtrNext;
      wrIdx      <= wrIdxNext;
      rdPending  <= (rdPending && !pendClear) || rdReq;
      slotUnused <= unusedNext;
    end
  end

  // pending entries span from the read index up to the write index
  for (genvar i = 0; i < DEPTH; i++) begin : g_valid
    logic [IDX_W-1:0] offset;
    assign offset = IDX_W'(i) - rdIdx;
    assign validMask[i] = !queueEmpty && (queueFull || offset < fillCount);
  end
endmodule

// File: rtl/swq_datapath.sv
module swq_datapath
  import swq_pkg::*;
#(
  parameter int DEPTH        = 4,
  parameter int SLOT_WIDE    = 16,
  parameter int SLOT_NARROW  = 20,
  parameter int FILL_LATENCY = 3,
  parameter int VSRAM_WORDS  = 40,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [DEPTH-1:0]  validMask,
  input  logic [TIME_W-1:0] nowTime,
  input  logic              wideMode,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgLoad,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CODE_W-1:0] cfgCode,
  input  logic [INC_W-1:0]  autoInc,
  input  logic [TIME_W-1:0] rebaseAmount,
  input  logic              rdSel,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdRaw,
  output logic              headReady,
  output logic [3:0]        headCode,
  output logic              headPartial,
  output logic              memWe,
  output logic [1:0]        memTarget,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] rdWord
);
  localparam logic [TIME_W-1:0] DELAY_WIDE   = TIME_W'(SLOT_WIDE * FILL_LATENCY);
  localparam logic [TIME_W-1:0] DELAY_NARROW = TIME_W'(SLOT_NARROW * FILL_LATENCY);
  localparam logic [DATA_W-1:0] CRAM_KEEP    = 16'h0EEE;
  localparam logic [DATA_W-1:0] VSRAM_KEEP   = 16'h03FF;
  localparam logic [DATA_W-1:0] VSRAM_STALE  = 16'hF800;

  entry_t            store [DEPTH];
  entry_t            head;
  entry_t            incoming;
  logic [ADDR_W-1:0] portAddr;
  logic [CODE_W-1:0] portCode;
  logic [DATA_W-1:0] staleValue;
  logic [5:0]        vsramIdx;
  target_e           headTarget;

  always_comb begin
    incoming.readyTime = nowTime + (wideMode ? DELAY_WIDE : DELAY_NARROW);
    incoming.addr      = portAddr;
    incoming.value     = wrData;
    incoming.code      = portCode;
    incoming.partial   = 1'b0;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    entry_t nextEntry;
    always_comb begin
      nextEntry = store[i];
      if (strobe.rebase && validMask[i])
        nextEntry.readyTime = (store[i].readyTime >= rebaseAmount)
                              ? store[i].readyTime - rebaseAmount : '0;
      if (strobe.markPartial && rdIdx == IDX_W'(i))
        nextEntry.partial = 1'b1;
      if (strobe.push && wrIdx == IDX_W'(i))
        nextEntry = incoming;
    end
    always_ff @(posedge clk) begin
      if (!rstN) store[i] <= '0;
      else       store[i] <= nextEntry;
    end
  end

  assign head        = store[rdIdx];
  assign headReady   = head.readyTime <= nowTime;
  assign headCode    = head.code[3:0];
  assign headPartial = head.partial;
  assign headTarget  = decodeTarget(head.code[3:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portAddr <= '0;
      portCode <= '0;
    end else if (cfgLoad) begin
      portAddr <= cfgAddr;
      portCode <= cfgCode;
    end else if (strobe.push) begin
      portAddr <= portAddr + ADDR_W'(autoInc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWe     <= 1'b0;
      memTarget <= '0;
      memAddr   <= '0;
      memData   <= '0;
    end else begin
      memWe <= 1'b0;
      if (strobe.emitHigh) begin
        memWe     <= 1'b1;
        memTarget <= TGT_VRAM;
        memAddr   <= head.addr;
        memData   <= {8'h00, head.value[15:8]};
      end else if (strobe.emitWord) begin
        memWe     <= 1'b1;
        memTarget <= headTarget;
        if (headTarget == TGT_VRAM) begin
          memAddr <= head.addr ^ 16'h0001;
          memData <= {8'h00, head.value[7:0]};
        end else begin
          memAddr <= head.addr;
          memData <= head.value;
        end
      end
    end
  end

  assign staleValue = store[wrIdx].value;
  assign vsramIdx   = rdAddr[6:1];

  always_comb begin
    if (!rdSel) begin
      rdWord = (rdRaw & CRAM_KEEP) | (staleValue & ~CRAM_KEEP);
    end else if (32'(vsramIdx) < VSRAM_WORDS) begin
      rdWord = (rdRaw & VSRAM_KEEP) | (staleValue & VSRAM_STALE);
    end else begin
      rdWord = '0;
    end
  end
endmodule

// File: rtl/slot_write_queue.sv
module slot_write_queue
  import swq_pkg::*;
#(
  parameter int DEPTH        = 4,
  parameter int SLOT_WIDE    = 16,
  parameter int SLOT_NARROW  = 20,
  parameter int FILL_LATENCY = 3,
  parameter int VSRAM_WORDS  = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] nowTime,
  input  logic        wideMode,
  input  logic        cfgLoad,
  input  logic [15:0] cfgAddr,
  input  logic [5:0]  cfgCode,
  input  logic [7:0]  autoInc,
  input  logic        wrValid,
  input  logic [15:0] wrData,
  output logic        wrReady,
  input  logic        slotTick,
  input  logic        rdReq,
  output logic        slotUnused,
  output logic        memWe,
  output logic [1:0]  memTarget,
  output logic [15:0] memAddr,
  output logic [15:0] memData,
  output logic [15:0] statusWord,
  input  logic        rdSel,
  input  logic [15:0] rdAddr,
  input  logic [15:0] rdRaw,
  output logic [15:0] rdWord,
  input  logic        rebaseValid,
  input  logic [31:0] rebaseAmount
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [15:0] STATUS_BASE = 16'h3400;

  ctrl_strobe_t     strobe;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;
  logic [DEPTH-1:0] validMask;
  logic             headReady;
  logic [3:0]       headCode;
  logic             headPartial;
  logic             queueEmpty;
  logic             queueFull;

  swq_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rstN, .wrValid, .slotTick, .rdReq, .rebaseValid,
    .headReady, .headCode, .headPartial,
    .strobe, .wrIdx, .rdIdx, .validMask,
    .wrReady, .queueEmpty, .queueFull, .slotUnused
  );

  swq_datapath #(
    .DEPTH(DEPTH), .SLOT_WIDE(SLOT_WIDE), .SLOT_NARROW(SLOT_NARROW),
    .FILL_LATENCY(FILL_LATENCY), .VSRAM_WORDS(VSRAM_WORDS)
  ) u_data (
    .clk, .rstN, .strobe, .wrIdx, .rdIdx, .validMask,
    .nowTime, .wideMode, .wrData, .cfgLoad, .cfgAddr, .cfgCode, .autoInc,
    .rebaseAmount, .rdSel, .rdAddr, .rdRaw,
    .headReady, .headCode, .headPartial,
    .memWe, .memTarget, .memAddr, .memData, .rdWord
  );

  assign statusWord = STATUS_BASE | {6'b0, queueEmpty, queueFull, 8'b0};
endmodule

// File: rtl/swq_checker.sv
module swq_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrValid,
  input logic        wrReady,
  input logic        slotTick,
  input logic        slotUnused,
  input logic        memWe,
  input logic [15:0] statusWord
);
  // R2: empty and full flags never both set
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(statusWord[9] && statusWord[8]));

  // R2: one slot removes at most one entry, so full never turns empty at once
  assert_full_not_to_empty_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[8] |=> !statusWord[9]);

  // R10: an accepted push leaves the queue non-empty
  assert_push_nonempty_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady) |=> !statusWord[9]);

  // R3: a write strobe only follows a granted slot
  assert_strobe_after_slot_R3: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(slotTick));

  // R4: a slot on an empty queue produces no write and flags unused
  assert_empty_slot_unused_R4: assert property (@(posedge clk) disable iff (!rstN)
    (slotTick && statusWord[9]) |=> (slotUnused && !memWe));

  // R8: unused flag and write strobe are exclusive
  assert_unused_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && slotUnused));
endmodule

bind slot_write_queue swq_checker u_swq_checker (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
  .slotTick(slotTick), .slotUnused(slotUnused), .memWe(memWe),
  .statusWord(statusWord)
);

// File: tb/tb_slot_write_queue.sv
module tb_slot_write_queue;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] nowTime = '0;
  logic        wideMode = 1'b1;
  logic        cfgLoad = 1'b0;
  logic [15:0] cfgAddr = '0;
  logic [5:0]  cfgCode = '0;
  logic [7:0]  autoInc = '0;
  logic        wrValid = 1'b0;
  logic [15:0] wrData = '0;
  logic        wrReady;
  logic        slotTick = 1'b0;
  logic        rdReq = 1'b0;
  logic        slotUnused;
  logic        memWe;
  logic [1:0]  memTarget;
  logic [15:0] memAddr;
  logic [15:0] memData;
  logic [15:0] statusWord;
  logic        rdSel = 1'b0;
  logic [15:0] rdAddr = '0;
  logic [15:0] rdRaw = '0;
  logic [15:0] rdWord;
  logic        rebaseValid = 1'b0;
  logic [31:0] rebaseAmount = '0;

  int errors = 0;
  int checks = 0;
  logic [15:0] hist [4];
  int wp = 0;

  slot_write_queue dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expStatus(input int cnt);
    return 16'h3400 | (cnt == 0 ? 16'h0200 : 16'h0) | (cnt == 4 ? 16'h0100 : 16'h0);
  endfunction

  function automatic logic [1:0] expTarget(input logic [3:0] c);
    return (c == 4'h1) ? 2'd0 : (c == 4'h3) ? 2'd1 : 2'd2;
  endfunction

  task automatic loadCfg(input logic [15:0] a, input logic [5:0] c, input logic [7:0] inc);
    cfgLoad = 1'b1; cfgAddr = a; cfgCode = c; autoInc = inc;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic doPush(input logic [15:0] d);
    wrValid = 1'b1; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
    hist[wp] = d; wp = (wp + 1) % 4;
  endtask

  task automatic doSlot();
    slotTick = 1'b1;
    @(negedge clk);
    slotTick = 1'b0;
  endtask

  task automatic expectDrain(input string req, input logic [1:0] t,
                             input logic [15:0] a, input logic [15:0] d);
    chk(req, memWe, 1'b1);
    chk(req, memTarget, t);
    chk(req, memAddr, a);
    chk(req, memData, d);
    chk(req, slotUnused, 1'b0);
  endtask

  task automatic expectIdle(input string req, input logic unused);
    chk(req, memWe, 1'b0);
    chk(req, slotUnused, unused);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] mTime [$];
    logic [15:0] mAddr [$];
    logic [15:0] mVal [$];
    logic [3:0]  mCode [$];
    logic        mPart [$];
    logic [15:0] curAddr;
    logic [3:0]  curCode;
    logic [7:0]  curInc;
    for (int i = 0; i < 4; i++) hist[i] = '0;
    void'($urandom(32'd24681));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 status", statusWord, 16'h3600);
    chk("R1 ready", wrReady, 1'b1);
    expectIdle("R1 outputs", 1'b0);

    // R4: slot on empty queue
    doSlot();
    expectIdle("R4 empty slot", 1'b1);

    // R7 R9 R3: palette writes with auto-increment, ready boundary
    wideMode = 1'b1; nowTime = 32'd100;
    loadCfg(16'h0010, 6'h03, 8'd2);
    doPush(16'h0ABC);
    doPush(16'h0123);
    chk("R9 not empty", statusWord, 16'h3400);
    nowTime = 32'd147;
    doSlot();
    expectIdle("R3 not ready", 1'b1);
    nowTime = 32'd148;
    doSlot();
    expectDrain("R7 R9 first word", 2'd1, 16'h0010, 16'h0ABC);
    doSlot();
    expectDrain("R9 incremented addr", 2'd1, 16'h0012, 16'h0123);
    chk("R10 empty after drain", statusWord, 16'h3600);

    // R6: video RAM two-slot drain
    loadCfg(16'h0200, 6'h01, 8'd1);
    doPush(16'hBEEF);
    nowTime = 32'd200;
    doSlot();
    expectDrain("R6 high byte", 2'd0, 16'h0200, 16'h00BE);
    chk("R6 still pending", statusWord, 16'h3400);
    doSlot();
    expectDrain("R6 low byte", 2'd0, 16'h0201, 16'h00EF);
    chk("R6 popped", statusWord, 16'h3600);

    // R2 R3 R10: fill in narrow mode, ignored push, ordered drain with wrap
    wideMode = 1'b0; nowTime = 32'd1000;
    loadCfg(16'h0000, 6'h05, 8'd1);
    doPush(16'hA001); doPush(16'hA002); doPush(16'hA003); doPush(16'hA004);
    chk("R2 full status", statusWord, 16'h3500);
    chk("R2 not ready", wrReady, 1'b0);
    wrValid = 1'b1; wrData = 16'hDEAD;
    @(negedge clk);
    wrValid = 1'b0;
    chk("R2 still full", statusWord, 16'h3500);
    nowTime = 32'd1059;
    doSlot();
    expectIdle("R3 narrow not ready", 1'b1);
    nowTime = 32'd1060;
    for (int i = 0; i < 4; i++) begin
      doSlot();
      expectDrain("R10 order", 2'd2, 16'(i), 16'hA001 + 16'(i));
    end
    chk("R2 ignored push", statusWord, 16'h3600);
    doPush(16'h5A5A);
    doSlot();
    expectIdle("R3 new entry waits", 1'b1);
    nowTime = 32'd1200;
    doSlot();
    expectDrain("R2 R9 addr skipped ignored push", 2'd2, 16'h0004, 16'h5A5A);

    // R5: pending read claims one slot
    loadCfg(16'h0040, 6'h03, 8'd2);
    doPush(16'h0777);
    nowTime = 32'd2000;
    rdReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0;
    doSlot();
    expectIdle("R5 read slot", 1'b1);
    chk("R5 entry kept", statusWord, 16'h3400);
    doSlot();
    expectDrain("R5 next slot drains", 2'd1, 16'h0040, 16'h0777);

    // R8: non-write code popped silently
    loadCfg(16'h0080, 6'h00, 8'd2);
    doPush(16'h1111);
    nowTime = 32'd3000;
    doSlot();
    expectIdle("R8 no strobe", 1'b0);
    chk("R8 popped", statusWord, 16'h3600);

    // R13: rebase with and without clamp
    wideMode = 1'b1; nowTime = 32'd5000;
    loadCfg(16'h0100, 6'h03, 8'd0);
    doPush(16'h0C0C);
    rebaseValid = 1'b1; rebaseAmount = 32'd5040;
    @(negedge clk);
    rebaseValid = 1'b0;
    nowTime = 32'd7;
    doSlot();
    expectIdle("R13 rebased not ready", 1'b1);
    nowTime = 32'd8;
    doSlot();
    expectDrain("R13 rebased ready", 2'd1, 16'h0100, 16'h0C0C);
    nowTime = 32'd10;
    doPush(16'h0D0D);
    rebaseValid = 1'b1; rebaseAmount = 32'd100;
    @(negedge clk);
    rebaseValid = 1'b0;
    nowTime = 32'd0;
    doSlot();
    expectDrain("R13 clamp to zero", 2'd1, 16'h0100, 16'h0D0D);

    // R11 R12: read merge from the write-index entry
    rdSel = 1'b0; rdRaw = 16'hFFFF;
    #1 chk("R11 palette merge", rdWord, 16'h0EEE | (hist[wp] & ~16'h0EEE));
    rdRaw = 16'h0000;
    #1 chk("R11 palette stale only", rdWord, hist[wp] & ~16'h0EEE);
    rdSel = 1'b1; rdAddr = 16'h0010; rdRaw = 16'hFFFF;
    #1 chk("R12 scroll merge", rdWord, 16'h03FF | (hist[wp] & 16'hF800));
    rdAddr = 16'h0050;
    #1 chk("R12 out of range", rdWord, 16'h0000);
    rdAddr = 16'h004E;
    #1 chk("R12 last index", rdWord, 16'h03FF | (hist[wp] & 16'hF800));
    rdSel = 1'b0;
    @(negedge clk);

    // Random mix checked against a queue model (R2 R3 R6 R7 R8 R9 R10 R11)
    wideMode = 1'b1; curAddr = 16'h0300; curCode = 4'h3; curInc = 8'd2;
    loadCfg(curAddr, 6'(curCode), curInc);
    for (int it = 0; it < 600; it++) begin
      logic doWr, doTk, doCfg, expWe, expUnused, accept;
      logic [1:0] eT;
      logic [15:0] eA, eD, d;
      int cnt;
      cnt = mTime.size();
      nowTime = nowTime + ($urandom % 12);
      doCfg = (($urandom % 16) == 0);
      doWr = !doCfg && ($urandom % 2);
      doTk = ($urandom % 2);
      d = 16'($urandom);
      chk("R2 ready vs count", wrReady, cnt < 4);
      chk("R2 status vs count", statusWord, expStatus(cnt));
      expWe = 1'b0; expUnused = 1'b0; eT = '0; eA = '0; eD = '0;
      if (doTk) begin
        if (cnt == 0 || mTime[0] > nowTime) expUnused = 1'b1;
        else if (mCode[0] == 4'h1 && !mPart[0]) begin
          expWe = 1'b1; eT = 2'd0; eA = mAddr[0]; eD = {8'h00, mVal[0][15:8]};
          mPart[0] = 1'b1;
        end else begin
          if (mCode[0] == 4'h1) begin
            expWe = 1'b1; eT = 2'd0; eA = mAddr[0] ^ 16'h1; eD = {8'h00, mVal[0][7:0]};
          end else if (mCode[0] == 4'h3 || mCode[0] == 4'h5) begin
            expWe = 1'b1; eT = expTarget(mCode[0]); eA = mAddr[0]; eD = mVal[0];
          end
          void'(mTime.pop_front()); void'(mAddr.pop_front()); void'(mVal.pop_front());
          void'(mCode.pop_front()); void'(mPart.pop_front());
        end
      end
      accept = doWr && (cnt < 4);
      if (accept) begin
        mTime.push_back(nowTime + 32'd48); mAddr.push_back(curAddr);
        mVal.push_back(d); mCode.push_back(curCode); mPart.push_back(1'b0);
        curAddr = curAddr + 16'(curInc);
        hist[wp] = d; wp = (wp + 1) % 4;
      end
      if (doCfg) begin
        case ($urandom % 4)
          0: curCode = 4'h0;
          1: curCode = 4'h1;
          2: curCode = 4'h3;
          default: curCode = 4'h5;
        endcase
        curAddr = 16'($urandom); curInc = 8'($urandom);
        cfgLoad = 1'b1; cfgAddr = curAddr; cfgCode = 6'(curCode); autoInc = curInc;
      end
      wrValid = doWr; wrData = d; slotTick = doTk;
      @(negedge clk);
      wrValid = 1'b0; slotTick = 1'b0; cfgLoad = 1'b0;
      chk("R10 random strobe", memWe, expWe);
      chk("R4 random unused", slotUnused, expUnused);
      if (expWe) begin
        chk("R6 R7 random target", memTarget, eT);
        chk("R9 random addr", memAddr, eA);
        chk("R6 R7 random data", memData, eD);
      end
      if ((it % 50) == 0) begin
        rdSel = 1'b0; rdRaw = 16'($urandom);
        #1 chk("R11 random merge", rdWord, (rdRaw & 16'h0EEE) | (hist[wp] & ~16'h0EEE));
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule